// File: doc/BRIEF.md
# Clock Control and Status Register

This block is a single 32-bit memory-mapped register for a clock-management unit. Software uses it to switch the on-chip RC oscillators, the high-speed crystal and the PLL on and off, to set the bypass and monitor options of the crystals, and to trim the 16 MHz RC oscillator. The same word shows the stable indications of every clock source, a failure flag for the low-speed crystal and the factory calibration value of the 16 MHz RC. The enables and the trim leave the block as plain level outputs toward the clock generators.

Some software writes are overridden by hardware. A PLL enable that is in use as the system clock cannot be switched off by software. A deep-sleep or standby entry pulse always switches the PLL off. The low-speed crystal failure flag is set by the detector and clears by itself once monitoring stops, the crystal is switched off or the crystal reports healthy again.

The word is at offset 0x00 of the peripheral window, so byte addresses 0x00 to 0x03 select it. Byte strobes choose which lanes a write changes. Reads are combinational.

Top module: `clkctl_reg`

## Requirements
- R1: After reset the word reads with bits 31:16 zero, bits 7:0 equal to 0x83 (16 MHz RC enabled, its stable flag set, trim 5'b10000) and bits 15:8 equal to `rc16_calib_i`.
- R2: A full write to offset 0 sets these fields, and each one reads back and drives its output: PLL enable bit 24, low-speed monitor enable bit 22, 48 MHz RC enable bit 20, high-speed monitor enable bit 19, high-speed bypass bit 18, high-speed enable bit 16, 16 MHz RC trim bits 7:3 and 16 MHz RC enable bit 0.
- R3: A write changes only the byte lanes whose `bus_wr_strb` bit is 1. Strobe bit n covers data bits 8n+7:8n.
- R4: Bits 31:26 and bit 2 always read 0, and writes to them have no effect.
- R5: The stable flags read at bit 25 (PLL), bit 21 (48 MHz RC), bit 17 (high-speed crystal) and bit 1 (16 MHz RC) follow their stable inputs one clock later. Software writes to these bits have no effect.
- R6: While `sysclk_sel_i` is 2'b10 (PLL selected), a write of 0 to bit 24 leaves the PLL enable at 1.
- R7: A high `deep_sleep_i` or `standby_i` in a cycle clears the PLL enable at that edge. This wins over a software write to bit 24 in the same cycle and over the selection interlock.
- R8: When the low-speed monitor enable is 1 and `lxt_on_i` is 1, a high `lxt_fail_i` sets the failure flag at bit 23, and the flag stays set after the input falls.
- R9: The failure flag clears one clock after any of these: the low-speed monitor enable is 0, `lxt_on_i` is 0, or `lxt_healthy_i` is 1.
- R10: A write of 1 to the low-speed monitor enable has no effect while `lxt_on_i` is 0.
- R11: An address outside the register word reads 0, and a write to it changes no state.
- R12: Bits 15:8 always show the current `rc16_calib_i`, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address within the peripheral window |
| bus_wr_en | input | 1 | Write request |
| bus_wr_strb | input | 4 | Byte-lane write strobes |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data, combinational from the address |
| pll_stable_i | input | 1 | PLL output is stable |
| hxt_stable_i | input | 1 | High-speed crystal is stable |
| rc48_stable_i | input | 1 | 48 MHz RC is stable |
| rc16_stable_i | input | 1 | 16 MHz RC is stable |
| lxt_fail_i | input | 1 | Low-speed crystal failure detected |
| lxt_healthy_i | input | 1 | Low-speed crystal reported healthy again |
| lxt_on_i | input | 1 | Low-speed crystal enable from its own control |
| sysclk_sel_i | input | 2 | Current system-clock source, 2'b10 = PLL |
| deep_sleep_i | input | 1 | Deep-sleep entry pulse |
| standby_i | input | 1 | Standby entry pulse |
| rc16_calib_i | input | 8 | Factory calibration of the 16 MHz RC |
| pll_en_o | output | 1 | PLL enable |
| lxt_mon_en_o | output | 1 | Low-speed crystal monitor enable |
| rc48_en_o | output | 1 | 48 MHz RC enable |
| hxt_mon_en_o | output | 1 | High-speed crystal monitor enable |
| hxt_bypass_o | output | 1 | High-speed crystal bypass |
| hxt_en_o | output | 1 | High-speed crystal enable |
| rc16_trim_o | output | 5 | 16 MHz RC trim |
| rc16_en_o | output | 1 | 16 MHz RC enable |

## Verification
The assertions assume that `lxt_fail_i` and `lxt_healthy_i` are never high in the same cycle. They also assume that the low-power pulses, the system-clock selection and the stable inputs are synchronous to `clk` and change only between edges. The stimulus changes every input on the falling edge and keeps the failure and healthy indications apart. It holds the stable inputs steady for at least one cycle before each read, so a read always sees the registered copy of the inputs.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned TRIM_W  = 5;
    localparam int unsigned CALIB_W = 8;

    // bit positions of the register word
    localparam int unsigned B_RC16_EN  = 0;
    localparam int unsigned B_RC16_STB = 1;
    localparam int unsigned B_TRIM_LO  = 3;
    localparam int unsigned B_CALIB_LO = 8;
    localparam int unsigned B_HXT_EN   = 16;
    localparam int unsigned B_HXT_STB  = 17;
    localparam int unsigned B_HXT_BYP  = 18;
    localparam int unsigned B_HXT_MON  = 19;
    localparam int unsigned B_RC48_EN  = 20;
    localparam int unsigned B_RC48_STB = 21;
    localparam int unsigned B_LXT_MON  = 22;
    localparam int unsigned B_LXT_FAIL = 23;
    localparam int unsigned B_PLL_EN   = 24;
    localparam int unsigned B_PLL_STB  = 25;

    // lanes that carry writable fields
    localparam int unsigned LANE_LOW  = 0;
    localparam int unsigned LANE_OSC  = 2;
    localparam int unsigned LANE_PLL  = 3;

    typedef enum logic [1:0] {
        SRC_RC16 = 2'b00,
        SRC_HXT  = 2'b01,
        SRC_PLL  = 2'b10,
        SRC_RSVD = 2'b11
    } sysclk_src_e;

    typedef struct packed {
        logic              rc48_en;
        logic              hxt_mon;
        logic              hxt_byp;
        logic              hxt_en;
        logic [TRIM_W-1:0] trim;
        logic              rc16_en;
    } sw_fields_t;

    typedef struct packed {
        logic pll;
        logic rc48;
        logic hxt;
        logic rc16;
    } stb_flags_t;

endpackage

// File: rtl/clkctl_bus_dec.sv
module clkctl_bus_dec
    import clkctl_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]  REG_OFFSET = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_strb,
    output logic              hit,
    output logic [LANES-1:0]  lane_we
);

    localparam int unsigned IDX_LO = $clog2(LANES);

    logic [IDX_LO-1:0] unused_byte_sel;

    assign unused_byte_sel = addr[IDX_LO-1:0];
    assign hit = (addr[ADDR_W-1:IDX_LO] == REG_OFFSET[ADDR_W-1:IDX_LO]);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = wr_en & hit & wr_strb[g];
    end

endmodule

// File: rtl/clkctl_pll_ctl.sv
module clkctl_pll_ctl
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_lane,
    input  logic       wr_bit,
    input  logic [1:0] sysclk_sel,
    input  logic       deep_sleep,
    input  logic       standby,
    output logic       pll_en
);

    typedef struct packed {
        logic en;
    } pll_state_t;

    pll_state_t state_d;
    pll_state_t state_q;
    logic       pll_in_use;
    logic       lp_entry;

    always_comb begin
        pll_in_use = (sysclk_src_e'(sysclk_sel) == SRC_PLL);
        lp_entry   = deep_sleep | standby;
        state_d    = state_q;
        if (lp_entry) begin
            state_d.en = 1'b0;
        end else if (wr_lane) begin
            state_d.en = wr_bit | (state_q.en & pll_in_use);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pll_en = state_q.en;

    p_pll_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && sysclk_sel == 2'b10 && !deep_sleep && !standby) |=> pll_en);

    p_lp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_sleep || standby) |=> !pll_en);

endmodule

// File: rtl/clkctl_lxt_mon.sv
module clkctl_lxt_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_lane,
    input  logic wr_bit,
    input  logic lxt_on,
    input  logic fail_det,
    input  logic healthy,
    output logic mon_en,
    output logic fail_flag
);

    typedef struct packed {
        logic mon;
        logic fail;
    } mon_state_t;

    mon_state_t state_d;
    mon_state_t state_q;
    logic       fail_clear;

    always_comb begin
        state_d    = state_q;
        fail_clear = ~state_q.mon | ~lxt_on | healthy;
        if (wr_lane) begin
            // a set only takes effect while the crystal is on
            state_d.mon = wr_bit & (state_q.mon | lxt_on);
        end
        if (fail_clear) begin
            state_d.fail = 1'b0;
        end else if (fail_det) begin
            state_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mon_en    = state_q.mon;
    assign fail_flag = state_q.fail;

    p_fail_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && lxt_on && !healthy && fail_det) |=> fail_flag);

    p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en || !lxt_on || healthy) |=> !fail_flag);

    p_mon_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lxt_on && !mon_en) |=> !mon_en);

endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
    import clkctl_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]  REG_OFFSET = '0,
    parameter logic [4:0]         TRIM_RST   = 5'b10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [3:0]        bus_wr_strb,
    input  logic [31:0]       bus_wr_data,
    output logic [31:0]       bus_rd_data,
    input  logic              pll_stable_i,
    input  logic              hxt_stable_i,
    input  logic              rc48_stable_i,
    input  logic              rc16_stable_i,
    input  logic              lxt_fail_i,
    input  logic              lxt_healthy_i,
    input  logic              lxt_on_i,
    input  logic [1:0]        sysclk_sel_i,
    input  logic              deep_sleep_i,
    input  logic              standby_i,
    input  logic [7:0]        rc16_calib_i,
    output logic              pll_en_o,
    output logic              lxt_mon_en_o,
    output logic              rc48_en_o,
    output logic              hxt_mon_en_o,
    output logic              hxt_bypass_o,
    output logic              hxt_en_o,
    output logic [4:0]        rc16_trim_o,
    output logic              rc16_en_o
);

    typedef struct packed {
        sw_fields_t sw;
        stb_flags_t stb;
    } core_state_t;

    localparam core_state_t CORE_RST = '{
        sw:  '{rc48_en: 1'b0, hxt_mon: 1'b0, hxt_byp: 1'b0, hxt_en: 1'b0,
               trim: TRIM_RST, rc16_en: 1'b1},
        stb: '{pll: 1'b0, rc48: 1'b0, hxt: 1'b0, rc16: 1'b1}
    };

    core_state_t      core_d;
    core_state_t      core_q;
    logic             hit;
    logic [LANES-1:0] lane_we;
    logic             pll_en;
    logic             lxt_mon;
    logic             lxt_fail;
    logic [31:0]      word;
    logic             unused_wdata;

    clkctl_bus_dec #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) i_dec (
        .addr    (bus_addr),
        .wr_en   (bus_wr_en),
        .wr_strb (bus_wr_strb),
        .hit     (hit),
        .lane_we (lane_we)
    );

    clkctl_pll_ctl i_pll (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lane    (lane_we[LANE_PLL]),
        .wr_bit     (bus_wr_data[B_PLL_EN]),
        .sysclk_sel (sysclk_sel_i),
        .deep_sleep (deep_sleep_i),
        .standby    (standby_i),
        .pll_en     (pll_en)
    );

    clkctl_lxt_mon i_lxt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lane   (lane_we[LANE_OSC]),
        .wr_bit    (bus_wr_data[B_LXT_MON]),
        .lxt_on    (lxt_on_i),
        .fail_det  (lxt_fail_i),
        .healthy   (lxt_healthy_i),
        .mon_en    (lxt_mon),
        .fail_flag (lxt_fail)
    );

    always_comb begin
        core_d          = core_q;
        core_d.stb.pll  = pll_stable_i;
        core_d.stb.rc48 = rc48_stable_i;
        core_d.stb.hxt  = hxt_stable_i;
        core_d.stb.rc16 = rc16_stable_i;
        if (lane_we[LANE_LOW]) begin
            core_d.sw.rc16_en = bus_wr_data[B_RC16_EN];
            core_d.sw.trim    = bus_wr_data[B_TRIM_LO +: TRIM_W];
        end
        if (lane_we[LANE_OSC]) begin
            core_d.sw.hxt_en  = bus_wr_data[B_HXT_EN];
            core_d.sw.hxt_byp = bus_wr_data[B_HXT_BYP];
            core_d.sw.hxt_mon = bus_wr_data[B_HXT_MON];
            core_d.sw.rc48_en = bus_wr_data[B_RC48_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= CORE_RST;
        end else begin
            core_q <= core_d;
        end
    end

    always_comb begin
        word = '0;
        word[B_RC16_EN]                = core_q.sw.rc16_en;
        word[B_RC16_STB]               = core_q.stb.rc16;
        word[B_TRIM_LO +: TRIM_W]      = core_q.sw.trim;
        word[B_CALIB_LO +: CALIB_W]    = rc16_calib_i;
        word[B_HXT_EN]                 = core_q.sw.hxt_en;
        word[B_HXT_STB]                = core_q.stb.hxt;
        word[B_HXT_BYP]                = core_q.sw.hxt_byp;
        word[B_HXT_MON]                = core_q.sw.hxt_mon;
        word[B_RC48_EN]                = core_q.sw.rc48_en;
        word[B_RC48_STB]               = core_q.stb.rc48;
        word[B_LXT_MON]                = lxt_mon;
        word[B_LXT_FAIL]               = lxt_fail;
        word[B_PLL_EN]                 = pll_en;
        word[B_PLL_STB]                = core_q.stb.pll;
        bus_rd_data = hit ? word : '0;
    end

    assign unused_wdata = ^{bus_wr_data[31:25], bus_wr_data[23], bus_wr_data[21],
                            bus_wr_data[17], bus_wr_data[15:8], bus_wr_data[2:1]};

    assign pll_en_o     = pll_en;
    assign lxt_mon_en_o = lxt_mon;
    assign rc48_en_o    = core_q.sw.rc48_en;
    assign hxt_mon_en_o = core_q.sw.hxt_mon;
    assign hxt_bypass_o = core_q.sw.hxt_byp;
    assign hxt_en_o     = core_q.sw.hxt_en;
    assign rc16_trim_o  = core_q.sw.trim;
    assign rc16_en_o    = core_q.sw.rc16_en;

    p_stable_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (core_q.stb.pll == $past(pll_stable_i)
                          && core_q.stb.hxt == $past(hxt_stable_i)));

    p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_we[LANE_LOW] |=> $stable(core_q.sw.trim));

    p_miss_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(core_q.sw) && $stable(pll_en) == 1'b1) || deep_sleep_i || standby_i
              || $past(deep_sleep_i) || $past(standby_i));

endmodule

// File: tb/test_clkctl_reg.sv
module test_clkctl_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  strb = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        s_pll = 1'b0, s_hxt = 1'b0, s_r48 = 1'b0, s_r16 = 1'b1;
    logic        fail_i = 1'b0, healthy_i = 1'b0, lxt_on = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        dsleep = 1'b0, stby = 1'b0;
    logic [7:0]  calib = 8'hA5;
    logic        o_pll, o_lmon, o_r48, o_hmon, o_hbyp, o_hen, o_r16;
    logic [4:0]  o_trim;

    int n_cmp = 0;
    int n_bad = 0;
    logic rd_req = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // expected software-visible state
    logic e_pll = 0, e_lmon = 0, e_fail = 0, e_r48e = 0, e_hmon = 0, e_hbyp = 0, e_hen = 0, e_r16e = 1;
    logic [4:0] e_trim = 5'b10000;

    always #4 clk = ~clk;

    clkctl_reg i_clkctl_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en),
        .bus_wr_strb(strb), .bus_wr_data(wdata), .bus_rd_data(rdata),
        .pll_stable_i(s_pll), .hxt_stable_i(s_hxt), .rc48_stable_i(s_r48),
        .rc16_stable_i(s_r16), .lxt_fail_i(fail_i), .lxt_healthy_i(healthy_i),
        .lxt_on_i(lxt_on), .sysclk_sel_i(sel), .deep_sleep_i(dsleep),
        .standby_i(stby), .rc16_calib_i(calib), .pll_en_o(o_pll),
        .lxt_mon_en_o(o_lmon), .rc48_en_o(o_r48), .hxt_mon_en_o(o_hmon),
        .hxt_bypass_o(o_hbyp), .hxt_en_o(o_hen), .rc16_trim_o(o_trim),
        .rc16_en_o(o_r16)
    );

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[25] = s_pll;  w[24] = e_pll;  w[23] = e_fail; w[22] = e_lmon;
        w[21] = s_r48;  w[20] = e_r48e; w[19] = e_hmon; w[18] = e_hbyp;
        w[17] = s_hxt;  w[16] = e_hen;  w[15:8] = calib; w[7:3] = e_trim;
        w[1] = s_r16;   w[0] = e_r16e;
        return w;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected read per request, samples after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rd_req) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard: actual empty queue expected item");
                end else begin
                    chk(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        addr = a; wdata = d; strb = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; strb = '0; addr = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        addr = '0;
    endtask

    task automatic pulse_fail();
        @(negedge clk); fail_i = 1'b1;
        @(negedge clk); fail_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(8'h00, 32'h0000_A583, "R1 reset word");
        chk("R1 trim out", {27'b0, o_trim}, 32'd16);
        chk("R1 rc16 enable out", {31'b0, o_r16}, 32'd1);

        // R2 full write; R10 monitor set blocked (crystal off); R4 reserved bits ignored
        bus_wr(8'h00, 32'hFFFF_FFFF, 4'hF);
        e_pll = 1; e_r48e = 1; e_hmon = 1; e_hbyp = 1; e_hen = 1; e_trim = 5'h1F; e_r16e = 1;
        rd_chk(8'h00, 32'h011D_A5FB, "R2 R4 R10 full write word");
        chk("R2 outputs", {o_pll, o_lmon, o_r48, o_hmon, o_hbyp, o_hen, o_trim, o_r16},
            {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 5'h1F, 1'b1});
        chk("R10 monitor enable out", {31'b0, o_lmon}, 32'd0);

        // R3 single byte lane
        bus_wr(8'h00, 32'h0000_0000, 4'b0001);
        e_trim = 0; e_r16e = 0;
        rd_chk(8'h00, model_word(), "R3 lane0 only");
        chk("R3 upper lanes kept", {31'b0, o_hen}, 32'd1);
        // R3 half-word upper lanes
        bus_wr(8'h02, 32'h0000_0000, 4'b1100);
        e_pll = 0; e_r48e = 0; e_hmon = 0; e_hbyp = 0; e_hen = 0;
        rd_chk(8'h00, 32'h0000_A502, "R3 upper half-word");

        // R11 unmapped offset
        bus_wr(8'h04, 32'hFFFF_FFFF, 4'hF);
        rd_chk(8'h04, 32'h0000_0000, "R11 unmapped read");
        rd_chk(8'h00, 32'h0000_A502, "R11 unmapped write ignored");

        // R5 stable flags follow inputs, writes have no effect
        @(negedge clk); s_pll = 1; s_r48 = 1; s_hxt = 1; s_r16 = 0;
        rd_chk(8'h00, 32'h0222_A500, "R5 stable flags");
        bus_wr(8'h00, 32'h0000_0000, 4'hF);
        rd_chk(8'h00, 32'h0222_A500, "R5 write to flags ignored");
        // R12 calibration read-only and live
        @(negedge clk); calib = 8'h3C;
        bus_wr(8'h00, 32'h0000_FF00, 4'b0010);
        rd_chk(8'h00, 32'h0222_3C00, "R12 calibration");

        // R6 interlock
        bus_wr(8'h00, 32'h0100_0000, 4'b1000);
        @(negedge clk); sel = 2'b10;
        bus_wr(8'h00, 32'h0000_0000, 4'b1000);
        chk("R6 clear blocked", {31'b0, o_pll}, 32'd1);
        @(negedge clk); sel = 2'b00;
        bus_wr(8'h00, 32'h0000_0000, 4'b1000);
        chk("R6 clear allowed", {31'b0, o_pll}, 32'd0);

        // R7 deep-sleep clears despite selection
        bus_wr(8'h00, 32'h0100_0000, 4'b1000);
        @(negedge clk); sel = 2'b10;
        @(negedge clk); dsleep = 1;
        @(negedge clk); dsleep = 0;
        chk("R7 deep-sleep clear", {31'b0, o_pll}, 32'd0);
        // R7 standby wins over a same-cycle write
        @(negedge clk); sel = 2'b00;
        addr = 8'h00; wdata = 32'h0100_0000; strb = 4'b1000; wr_en = 1; stby = 1;
        @(negedge clk); wr_en = 0; strb = 0; stby = 0;
        chk("R7 standby priority", {31'b0, o_pll}, 32'd0);

        // R10 set ignored with crystal off, then allowed
        bus_wr(8'h00, 32'h0040_0000, 4'b0100);
        chk("R10 set blocked", {31'b0, o_lmon}, 32'd0);
        @(negedge clk); lxt_on = 1;
        bus_wr(8'h00, 32'h0040_0000, 4'b0100);
        e_lmon = 1;
        chk("R10 set accepted", {31'b0, o_lmon}, 32'd1);

        // R8 set and hold; R9 healthy clears
        pulse_fail();
        e_fail = 1;
        rd_chk(8'h00, model_word(), "R8 failure flag set");
        @(negedge clk); healthy_i = 1;
        @(negedge clk); healthy_i = 0;
        e_fail = 0;
        rd_chk(8'h00, model_word(), "R9 cleared by healthy");
        // R9 crystal off clears
        pulse_fail();
        rd_chk(8'h00, 32'h02E2_3C00, "R8 failure flag set again");
        @(negedge clk); lxt_on = 0;
        rd_chk(8'h00, model_word(), "R9 cleared by crystal off");
        @(negedge clk); lxt_on = 1;
        // R9 monitor disable clears
        pulse_fail();
        bus_wr(8'h00, 32'h0000_0000, 4'b0100);
        e_lmon = 0;
        rd_chk(8'h00, model_word(), "R9 cleared by monitor disable");
        pulse_fail();
        rd_chk(8'h00, model_word(), "R8 no set while monitor off");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule